// File: doc/BRIEF.md
# Stream-to-memory DMA destination channel

This block is the write half of a simple DMA. Software programs a start address, arms a transfer by writing a byte count, and the channel then takes 32-bit words from a valid/ready stream. Each word goes into a one-word holding buffer and is written to memory through a single-word request/acknowledge port that can return an error. Every accepted word is also folded into a running checksum. When the endianness control bit is set, the word is byte-swapped on its way to memory.

The channel drives stream ready only while a transfer is armed, not paused and the holding buffer is empty. A word offered while the channel is paused or unarmed is not stalled: it is discarded and an overflow flag is raised. Completion, memory errors and overflows are reported as sticky flags that are cleared by writing ones, with a per-flag mask in front of a single interrupt output. Software reaches the registers through a word-indexed write/read port. Reads have no side effects.

Top module: `dst_dma_chan`

## Requirements
- R1: After reset the control register (index 3) reads 0x803FFA00, the interrupt mask (index 8) reads 0xFF, and size (index 1), status (index 2), flags (index 5) and checksum (index 4) read 0. After reset irq_o, s_ready_o and mem_req_o are low.
- R2: s_ready_o is high only when the remaining size is nonzero, both pause bits (control bits 0 and 1) are clear, and no word is waiting to be written. A size write raises s_ready_o on the next clock.
- R3: A stream word offered while a pause bit is set or while the size is zero is dropped without a memory request, and it sets flag bit 7 (overflow).
- R4: Each accepted word produces exactly one memory request. The request holds its data stable until mem_ack_i. Its address comes from the address register (index 0, bits 1:0 forced to 0). The address rises by 4 after each acknowledge unless control bit 22 (fixed address) is set.
- R5: When control bit 23 is set, the memory data is the accepted word with its four bytes reversed. Otherwise the word is written unchanged.
- R6: On each accepted word, the unswapped word is added modulo 2^32 into the checksum register (index 4), which software may overwrite.
- R7: An acknowledge with mem_err_i high sets flag bit 2. The transfer still advances past that word.
- R8: When the last word of a transfer is acknowledged, or when size 0 is written, the busy bit (status bit 0) clears, flag bits 1 and 0 are set, and the done count (status bits 15:13) increments.
- R9: Writing ones to the flag register clears those flags. Clearing flag bit 1 while it is set decrements the done count.
- R10: irq_o is high when any flag is set whose mask bit is clear. Writing ones to index 6 clears mask bits, and writing ones to index 7 sets them.
- R11: A size write while a transfer is still in progress is ignored.
- R12: In the cycle after a word is accepted, s_ready_o is low, so no word beyond the programmed count is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_idx_i |
| s_valid_i | input | 1 | Stream word valid |
| s_data_i | input | 32 | Stream word |
| s_ready_o | output | 1 | Stream ready |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 32 | Memory write byte address |
| mem_data_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory write acknowledge |
| mem_err_i | input | 1 | Memory error, valid with acknowledge |
| irq_o | output | 1 | Interrupt |

## Verification
On every cycle, the assertions check the following: a request holds its data until acknowledged, ready falls after each accepted word, the address steps by one word per acknowledge, a dropped word never starts a request, and size writes during a transfer are ignored. They also check that each overflow, error and final acknowledge raises its flag on the next clock. Only the bench scenarios can show the end-to-end results: the memory sees exactly the programmed words at the expected addresses, the byte order follows the swap bit, and the checksum equals the arithmetic sum. The bench also covers done-count bookkeeping across flag clears, mask-gated interrupts, and the zero-size start. The sweep covers lengths of one to four words with every combination of fixed address, byte swap and acknowledge latencies of 0 to 2 cycles.

// File: rtl/dst_dma_pkg.sv
package dst_dma_pkg;
  localparam int unsigned IDX_ADDR   = 0;
  localparam int unsigned IDX_SIZE   = 1;
  localparam int unsigned IDX_STAT   = 2;
  localparam int unsigned IDX_CTRL   = 3;
  localparam int unsigned IDX_CSUM   = 4;
  localparam int unsigned IDX_FLAGS  = 5;
  localparam int unsigned IDX_UNMASK = 6;
  localparam int unsigned IDX_MASK   = 7;
  localparam int unsigned IDX_MASKRD = 8;

  localparam logic [31:0] CTRL_RST = 32'h803F_FA00;

  localparam int unsigned CB_PAUSE_MEM  = 0;
  localparam int unsigned CB_PAUSE_STRM = 1;
  localparam int unsigned CB_FIXED      = 22;
  localparam int unsigned CB_SWAP       = 23;

  localparam int unsigned FB_MEM_DONE = 0;
  localparam int unsigned FB_DONE     = 1;
  localparam int unsigned FB_BUS_ERR  = 2;
  localparam int unsigned FB_OVF      = 7;

  localparam int unsigned SB_BUSY    = 0;
  localparam int unsigned SB_CNT_LSB = 13;

  function automatic logic [31:0] swap_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/dst_dma_engine.sv
module dst_dma_engine
  import dst_dma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        s_valid_i,
  input  logic [31:0] s_data_i,
  output logic        s_ready_o,
  input  logic        armed_i,
  input  logic        paused_i,
  input  logic        swap_i,
  output logic        mem_req_o,
  output logic [31:0] mem_data_o,
  input  logic        mem_ack_i,
  input  logic        mem_err_i,
  output logic        acc_o,
  output logic [31:0] acc_word_o,
  output logic        word_done_o,
  output logic        wr_err_o,
  output logic        ovf_o
);
  logic        full_q;
  logic [31:0] buf_q;

  assign s_ready_o   = armed_i && !paused_i && !full_q;
  assign acc_o       = s_valid_i && s_ready_o;
  assign acc_word_o  = s_data_i;
  assign ovf_o       = s_valid_i && (paused_i || !armed_i);
  assign mem_req_o   = full_q;
  assign mem_data_o  = buf_q;
  assign word_done_o = full_q && mem_ack_i;
  assign wr_err_o    = word_done_o && mem_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else if (acc_o) begin
      full_q <= 1'b1;
      buf_q  <= swap_i ? swap_bytes(s_data_i) : s_data_i;
    end else if (word_done_o) begin
      full_q <= 1'b0;
    end
  end

  p_hold_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_data_o));
  p_one_word_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_valid_i && s_ready_o |=> !s_ready_o);
  p_drop_no_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !mem_req_o |=> !mem_req_o);
endmodule

// File: rtl/dst_dma_regs.sv
module dst_dma_regs
  import dst_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 29,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned NFLG   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              acc_i,
  input  logic [31:0]       acc_word_i,
  input  logic              word_done_i,
  input  logic              wr_err_i,
  input  logic              ovf_i,
  output logic              armed_o,
  output logic              paused_o,
  output logic              swap_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              irq_o
);
  localparam int unsigned WORD_B = 4;
  localparam logic [SIZE_W-1:0] SIZE_STEP = SIZE_W'(WORD_B);

  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q, size_wr;
  logic [31:0]       ctrl_q, csum_q;
  logic [NFLG-1:0]   flg_q, mask_q, flg_set, flg_clr;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              wr_size, last_ack, done_evt;

  function automatic logic hit(input int unsigned idx);
    return reg_we_i && (reg_idx_i == IDX_W'(idx));
  endfunction

  assign armed_o  = (size_q != '0);
  assign paused_o = ctrl_q[CB_PAUSE_MEM] || ctrl_q[CB_PAUSE_STRM];
  assign swap_o   = ctrl_q[CB_SWAP];
  assign addr_o   = addr_q;

  assign size_wr  = {reg_wdata_i[SIZE_W-1:2], 2'b00};
  assign wr_size  = hit(IDX_SIZE) && !armed_o;
  assign last_ack = word_done_i && (size_q == SIZE_STEP);
  assign done_evt = last_ack || (wr_size && size_wr == '0);

  always_comb begin
    flg_set              = '0;
    flg_set[FB_OVF]      = ovf_i;
    flg_set[FB_BUS_ERR]  = wr_err_i;
    flg_set[FB_DONE]     = done_evt;
    flg_set[FB_MEM_DONE] = done_evt;
    flg_clr = hit(IDX_FLAGS) ? reg_wdata_i[NFLG-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      size_q <= '0;
      ctrl_q <= CTRL_RST;
      csum_q <= '0;
      flg_q  <= '0;
      mask_q <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (hit(IDX_ADDR))                        addr_q <= {reg_wdata_i[ADDR_W-1:2], 2'b00};
      else if (word_done_i && !ctrl_q[CB_FIXED]) addr_q <= addr_q + ADDR_W'(WORD_B);

      if (wr_size)          size_q <= size_wr;
      else if (word_done_i) size_q <= size_q - SIZE_STEP;

      if (done_evt)     busy_q <= 1'b0;
      else if (wr_size) busy_q <= 1'b1;

      if (hit(IDX_CTRL)) ctrl_q <= reg_wdata_i;

      if (hit(IDX_CSUM)) csum_q <= reg_wdata_i;
      else if (acc_i)    csum_q <= csum_q + acc_word_i;

      flg_q <= (flg_q & ~flg_clr) | flg_set;
      cnt_q <= cnt_q + CNT_W'(done_evt) - CNT_W'(flg_clr[FB_DONE] && flg_q[FB_DONE]);

      if (hit(IDX_UNMASK))    mask_q <= mask_q & ~reg_wdata_i[NFLG-1:0];
      else if (hit(IDX_MASK)) mask_q <= mask_q | reg_wdata_i[NFLG-1:0];
    end
  end

  assign irq_o = |(flg_q & ~mask_q);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_idx_i)
      IDX_W'(IDX_ADDR):   reg_rdata_o = 32'(addr_q);
      IDX_W'(IDX_SIZE):   reg_rdata_o = 32'(size_q);
      IDX_W'(IDX_STAT): begin
        reg_rdata_o[SB_BUSY] = busy_q;
        reg_rdata_o[SB_CNT_LSB +: CNT_W] = cnt_q;
      end
      IDX_W'(IDX_CTRL):   reg_rdata_o = ctrl_q;
      IDX_W'(IDX_CSUM):   reg_rdata_o = csum_q;
      IDX_W'(IDX_FLAGS):  reg_rdata_o = 32'(flg_q);
      IDX_W'(IDX_MASKRD): reg_rdata_o = 32'(mask_q);
      default:            reg_rdata_o = '0;
    endcase
  end

  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_i && !ctrl_q[CB_FIXED] && !hit(IDX_ADDR)
    |=> addr_q == $past(addr_q) + ADDR_W'(WORD_B));
  p_done_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_ack |=> flg_q[FB_DONE] && flg_q[FB_MEM_DONE] && !busy_q);
  p_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flg_q[FB_OVF]);
  p_bus_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_i |=> flg_q[FB_BUS_ERR]);
  p_size_locked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && hit(IDX_SIZE) && !word_done_i |=> size_q == $past(size_q));
endmodule

// File: rtl/dst_dma_chan.sv
module dst_dma_chan
  import dst_dma_pkg::*;
#(
  parameter int unsigned SIZE_W = 29,
  parameter int unsigned CNT_W  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_idx_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        s_valid_i,
  input  logic [31:0] s_data_i,
  output logic        s_ready_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_data_o,
  input  logic        mem_ack_i,
  input  logic        mem_err_i,
  output logic        irq_o
);
  logic        armed, paused, swap, acc, word_done, wr_err, ovf;
  logic [31:0] acc_word;

  dst_dma_engine u_engine (
    .clk_i, .rst_ni, .s_valid_i, .s_data_i, .s_ready_o,
    .armed_i(armed), .paused_i(paused), .swap_i(swap),
    .mem_req_o, .mem_data_o, .mem_ack_i, .mem_err_i,
    .acc_o(acc), .acc_word_o(acc_word), .word_done_o(word_done),
    .wr_err_o(wr_err), .ovf_o(ovf)
  );

  dst_dma_regs #(
    .ADDR_W(32), .SIZE_W(SIZE_W), .IDX_W(4), .CNT_W(CNT_W), .NFLG(8)
  ) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_idx_i, .reg_wdata_i, .reg_rdata_o,
    .acc_i(acc), .acc_word_i(acc_word), .word_done_i(word_done),
    .wr_err_i(wr_err), .ovf_i(ovf),
    .armed_o(armed), .paused_o(paused), .swap_o(swap),
    .addr_o(mem_addr_o), .irq_o
  );
endmodule

// File: tb/dst_dma_chan_tb_top.sv
`timescale 1ns/1ps
module dst_dma_chan_tb_top;
  localparam logic [31:0] CTRL_RST = 32'h803F_FA00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, mem_req, irq;
  logic [31:0] mem_addr, mem_data;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int lat = 0;
  int wcnt = 0;
  int log_n = 0;
  logic [31:0] log_addr [1024];
  logic [31:0] log_data [1024];

  always #2 clk = ~clk;

  dst_dma_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_idx_i(reg_idx),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .s_valid_i(s_valid),
    .s_data_i(s_data), .s_ready_o(s_ready), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ack_i(mem_ack),
    .mem_err_i(mem_err), .irq_o(irq)
  );

  // memory model: ack after lat idle cycles, error for addresses 0xExx
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        mem_err = (mem_addr[11:8] == 4'hE);
        if (log_n < 1024) begin
          log_addr[log_n] = mem_addr;
          log_data[log_n] = mem_data;
        end
        log_n++;
        wcnt = 0;
      end else wcnt++;
    end else begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 4'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = 4'(idx);
    #1 d = reg_rdata;
  endtask

  task automatic send_word(input logic [31:0] d, output logic ok);
    logic got;
    got = 1'b0;
    @(negedge clk);
    s_valid = 1'b1; s_data = d;
    for (int k = 0; k < 50 && !got; k++) begin
      #1 got = s_ready;
      @(negedge clk);
    end
    s_valid = 1'b0;
    ok = got;
  endtask

  task automatic drop_pulse();
    @(negedge clk);
    s_valid = 1'b1; s_data = 32'hDEAD_BEEF;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    logic idle;
    idle = 1'b0;
    for (int k = 0; k < 100 && !idle; k++) begin
      rd(2, s);
      idle = !s[0];
    end
    chk("R8 busy clears", 32'(idle), 32'd1);
  endtask

  function automatic logic [31:0] pat(input int t, input int i);
    return {8'(i + 1), 8'(t), 8'hA5, 8'(i * 3 + t)};
  endfunction

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic run_xfer(input int t, input int n, input logic fixed, input logic swp, input int l);
    logic [31:0] base, sum, v, ea;
    logic ok;
    int n0;
    lat = l;
    base = 32'h100 + 32'(t * 64);
    sum = '0;
    wr(3, CTRL_RST | (32'(fixed) << 22) | (32'(swp) << 23));
    wr(0, base);
    wr(4, 32'h0);
    n0 = log_n;
    #1 chk("R2 ready low while unarmed", 32'(s_ready), 32'd0);
    wr(1, 32'(n * 4));
    #1 chk("R2 ready one clock after size write", 32'(s_ready), 32'd1);
    for (int i = 0; i < n; i++) begin
      send_word(pat(t, i), ok);
      sum += pat(t, i);
      if (!ok) chk("R2 word accepted", 32'd0, 32'd1);
      if (i == n - 1) begin
        #1 chk("R12 ready low after final word", 32'(s_ready), 32'd0);
      end
    end
    wait_idle();
    chk("R4 write count", 32'(log_n - n0), 32'(n));
    for (int i = 0; i < n; i++) begin
      ea = fixed ? base : base + 32'(4 * i);
      chk("R4 write address", log_addr[n0 + i], ea);
      chk("R5 write data", log_data[n0 + i], swp ? bsw(pat(t, i)) : pat(t, i));
    end
    rd(0, v); chk("R4 final address", v, fixed ? base : base + 32'(4 * n));
    rd(4, v); chk("R6 checksum", v, sum);
    rd(5, v); chk("R8 done flags", v, 32'h3);
    rd(2, v); chk("R8 done count", (v >> 13) & 32'h7, 32'd1);
    rd(1, v); chk("R8 size zero", v, 32'd0);
    wr(5, 32'hFF);
    rd(2, v); chk("R9 done count decrements", (v >> 13) & 32'h7, 32'd0);
    rd(5, v); chk("R9 flags cleared", v, 32'h0);
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic ok;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3, v); chk("R1 ctrl reset", v, CTRL_RST);
    rd(8, v); chk("R1 mask reset", v, 32'hFF);
    rd(1, v); chk("R1 size reset", v, 32'h0);
    rd(2, v); chk("R1 status reset", v, 32'h0);
    rd(5, v); chk("R1 flags reset", v, 32'h0);
    rd(4, v); chk("R1 checksum reset", v, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'd0);
    chk("R1 ready reset", 32'(s_ready), 32'd0);
    chk("R1 req reset", 32'(mem_req), 32'd0);

    // R3 data while unarmed
    n0 = log_n;
    drop_pulse();
    repeat (3) @(negedge clk);
    rd(5, v); chk("R3 overflow when unarmed", v, 32'h80);
    chk("R3 no write when unarmed", 32'(log_n - n0), 32'd0);
    chk("R10 masked flag keeps irq low", 32'(irq), 32'd0);
    wr(5, 32'h80);

    // R8 zero-size start
    wr(1, 32'h0);
    rd(5, v); chk("R8 zero size flags", v, 32'h3);
    rd(2, v); chk("R8 zero size status", v, 32'h2000);
    wr(5, 32'hFF);

    // sweep
    for (int n = 1; n <= 4; n++)
      for (int f = 0; f < 2; f++)
        for (int s = 0; s < 2; s++)
          for (int l = 0; l < 3; l++)
            run_xfer((n - 1) * 12 + f * 6 + s * 3 + l, n, 1'(f), 1'(s), l);

    // R2/R3 pause behaviour
    lat = 1;
    wr(0, 32'h0D00);
    wr(1, 32'd8);
    wr(3, CTRL_RST | 32'h1);
    #1 chk("R2 ready low with pause bit 0", 32'(s_ready), 32'd0);
    n0 = log_n;
    drop_pulse();
    repeat (3) @(negedge clk);
    rd(5, v); chk("R3 overflow while paused", v, 32'h80);
    chk("R3 no write while paused", 32'(log_n - n0), 32'd0);
    wr(3, CTRL_RST | 32'h2);
    #1 chk("R2 ready low with pause bit 1", 32'(s_ready), 32'd0);
    wr(3, CTRL_RST);
    #1 chk("R2 ready after unpause", 32'(s_ready), 32'd1);
    send_word(32'h1111_2222, ok);
    send_word(32'h3333_4444, ok);
    wait_idle();
    chk("R4 writes after unpause", 32'(log_n - n0), 32'd2);
    wr(5, 32'hFF);

    // R7 error, R10 interrupt masking
    wr(0, 32'h0E00);
    wr(1, 32'd8);
    send_word(32'h5, ok);
    send_word(32'h6, ok);
    wait_idle();
    rd(5, v); chk("R7 error and completion flags", v, 32'h7);
    rd(0, v); chk("R7 address advances past error", v, 32'h0E08);
    chk("R10 irq low while masked", 32'(irq), 32'd0);
    wr(6, 32'h4);
    rd(8, v); chk("R10 unmask clears bit", v, 32'hFB);
    chk("R10 irq on unmasked flag", 32'(irq), 32'd1);
    wr(7, 32'h4);
    rd(8, v); chk("R10 mask sets bit", v, 32'hFF);
    chk("R10 irq low after remask", 32'(irq), 32'd0);
    wr(5, 32'hFF);

    // R11 size write while busy
    lat = 0;
    wr(0, 32'h0C00);
    n0 = log_n;
    wr(1, 32'd12);
    send_word(32'hA, ok);
    repeat (3) @(negedge clk);
    wr(1, 32'd40);
    rd(1, v); chk("R11 size write ignored while busy", v, 32'd8);
    send_word(32'hB, ok);
    send_word(32'hC, ok);
    wait_idle();
    chk("R11 original count written", 32'(log_n - n0), 32'd3);
    wr(5, 32'hFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule